// File: doc/BRIEF.md
# Mode Register Write Command Engine

This block sits inside a DRAM controller. Software uses it to write DRAM mode registers. Software first stores a mode register address and an 8-bit value in a data register. It then writes a control word that carries a rank selection mask and a start bit. The engine latches the request and turns it into one downstream command per selected rank. Each command is presented on a valid/ready command port.

While a request is in flight, a status bit reads as busy and both request registers are frozen. Any write to them is dropped, including a new start. Software polls the busy bit before it programs the next request. The engine walks the selected ranks from the lowest index upwards. A start with an empty rank mask completes at once and sends nothing.

Top module: `mrw_engine`

## Requirements
- R1: After synchronous reset, busy is 0, `cmd_valid` is 0, and both the control and data registers read back as 0.
- R2: The register map is indexed by `csr_addr`. Offset 0 is status, with busy in bit 0. Offset 1 is control, with the rank mask in bits 5:4 and the start bit in bit 31. Offset 2 is data, with the mode register address in bits 15:8 and the value in bits 7:0. Fields read back as written and all other bits read as 0.
- R3: The start bit is not stored and always reads back as 0.
- R4: A start written with a non-zero mask while idle sets busy in the next cycle. In that same cycle `cmd_valid` rises, carrying the stored address and value.
- R5: With mask 3, rank 0 is sent first and rank 1 second, as two separate commands.
- R6: While `cmd_ready` is low, `cmd_valid` stays high and `cmd_rank`, `cmd_mr_addr` and `cmd_mr_data` do not change.
- R7: Busy and `cmd_valid` fall in the cycle after the handshake of the last selected rank.
- R8: Any register write made while busy is set is ignored. This covers a write in the same cycle as the final handshake. Neither register changes, and an ignored start issues no command.
- R9: A start with mask 0 issues no command and leaves busy at 0.
- R10: A start sends the address and value from the data register written earlier, and the rank mask from the start write itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register offset for both writes and reads |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Combinational read data for `csr_addr` |
| busy | output | 1 | Request in flight |
| cmd_valid | output | 1 | Downstream command valid |
| cmd_rank | output | 1 | Rank index of the current command |
| cmd_mr_addr | output | 8 | Mode register address |
| cmd_mr_data | output | 8 | Mode register value |
| cmd_ready | input | 1 | Downstream command accept |

## Verification
Two functions can fall in the same cycle: the handshake of the last rank, which ends busy, and a software register write. At that edge busy is still high, so the write must be dropped.

The bench provokes this case at the final handshake with two kinds of write. One is a data-register write carrying new contents. The other is a fresh start with both ranks selected. It then judges the outcome through the normal interface: the data register must read back unchanged, and no further command may appear.

// File: rtl/mrw_pkg.sv
package mrw_pkg;

    localparam int CSR_AW = 2;
    localparam int CSR_DW = 32;
    localparam int MR_AW  = 8;
    localparam int MR_DW  = 8;

    localparam logic [CSR_AW-1:0] OFS_STATUS = 2'd0;
    localparam logic [CSR_AW-1:0] OFS_CTRL   = 2'd1;
    localparam logic [CSR_AW-1:0] OFS_DATA   = 2'd2;

    localparam int TRIG_BIT = 31;
    localparam int RANK_LSB = 4;
    localparam int MRA_LSB  = 8;

    typedef enum logic {
        SEQ_IDLE,
        SEQ_SEND
    } seq_state_e;

    typedef struct packed {
        logic [MR_AW-1:0] mra;
        logic [MR_DW-1:0] val;
    } mr_req_t;

    function automatic int unsigned first_set(input logic [31:0] v);
        int unsigned idx;
        idx = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/mrw_csr.sv
module mrw_csr
    import mrw_pkg::*;
#(
    parameter int NUM_RANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CSR_AW-1:0]    addr,
    input  logic [CSR_DW-1:0]    wdata,
    input  logic                 busy,
    output logic [CSR_DW-1:0]    rdata,
    output logic                 launch,
    output logic [NUM_RANKS-1:0] launch_mask,
    output mr_req_t              req
);

    logic                 accept;
    logic [NUM_RANKS-1:0] rank_q;

    assign accept      = wr_en && !busy;
    assign launch      = accept && (addr == OFS_CTRL) && wdata[TRIG_BIT];
    assign launch_mask = wdata[RANK_LSB +: NUM_RANKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            rank_q <= '0;
            req    <= '0;
        end else if (accept) begin
            case (addr)
                OFS_CTRL: rank_q <= wdata[RANK_LSB +: NUM_RANKS];
                OFS_DATA: begin
                    req.mra <= wdata[MRA_LSB +: MR_AW];
                    req.val <= wdata[MR_DW-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_STATUS: rdata[0] = busy;
            OFS_CTRL:   rdata[RANK_LSB +: NUM_RANKS] = rank_q;
            OFS_DATA: begin
                rdata[MRA_LSB +: MR_AW] = req.mra;
                rdata[MR_DW-1:0]        = req.val;
            end
            default: ;
        endcase
    end

    // R8: request registers frozen while busy
    p_locked_regs_r8: assert property (@(posedge clk) disable iff (rst)
        busy && wr_en |=> $stable(rank_q) && $stable(req));

    // R3: start bit never reads back
    p_trig_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !rdata[TRIG_BIT]);

endmodule

// File: rtl/mrw_seq.sv
module mrw_seq
    import mrw_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    localparam int RIW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch,
    input  logic [NUM_RANKS-1:0] launch_mask,
    input  logic                 cmd_ready,
    output logic                 busy,
    output logic                 cmd_valid,
    output logic [RIW-1:0]       cmd_rank
);

    seq_state_e           state;
    logic [NUM_RANKS-1:0] pending;
    logic [NUM_RANKS-1:0] remain;

    assign cmd_rank  = RIW'(first_set(32'(pending)));
    assign cmd_valid = (state == SEQ_SEND);
    assign busy      = (state != SEQ_IDLE);
    assign remain    = pending & ~(NUM_RANKS'(1) << cmd_rank);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            pending <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (launch && (|launch_mask)) begin
                        pending <= launch_mask;
                        state   <= SEQ_SEND;
                    end
                end
                SEQ_SEND: begin
                    if (cmd_ready) begin
                        pending <= remain;
                        if (remain == '0) state <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R4: busy follows a start with a non-empty mask
    p_busy_rise_r4: assert property (@(posedge clk) disable iff (rst)
        launch && (|launch_mask) && !busy |=> busy && cmd_valid);

    // R9: empty mask issues nothing
    p_empty_mask_r9: assert property (@(posedge clk) disable iff (rst)
        launch && (launch_mask == '0) && !busy |=> !busy && !cmd_valid);

    // R6: command holds under back-pressure
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_rank));

    // R5: ranks go out in ascending order
    p_order_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !cmd_valid || (cmd_rank > $past(cmd_rank)));

    // R7: busy only ends on a handshake
    p_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cmd_valid && cmd_ready));

endmodule

// File: rtl/mrw_engine.sv
module mrw_engine
    import mrw_pkg::*;
#(
    parameter int NUM_RANKS = 2,
    localparam int RIW = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    output logic              busy,
    output logic              cmd_valid,
    output logic [RIW-1:0]    cmd_rank,
    output logic [MR_AW-1:0]  cmd_mr_addr,
    output logic [MR_DW-1:0]  cmd_mr_data,
    input  logic              cmd_ready
);

    logic                 launch;
    logic [NUM_RANKS-1:0] launch_mask;
    mr_req_t              req;

    mrw_csr #(.NUM_RANKS(NUM_RANKS)) u_csr (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (csr_wr),
        .addr       (csr_addr),
        .wdata      (csr_wdata),
        .busy       (busy),
        .rdata      (csr_rdata),
        .launch     (launch),
        .launch_mask(launch_mask),
        .req        (req)
    );

    mrw_seq #(.NUM_RANKS(NUM_RANKS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_mask(launch_mask),
        .cmd_ready  (cmd_ready),
        .busy       (busy),
        .cmd_valid  (cmd_valid),
        .cmd_rank   (cmd_rank)
    );

    assign cmd_mr_addr = req.mra;
    assign cmd_mr_data = req.val;

    // R6: payload stable under back-pressure
    p_payload_hold_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> $stable(cmd_mr_addr) && $stable(cmd_mr_data));

endmodule

// File: tb/mrw_engine_tb_top.sv
`timescale 1ns/1ps
module mrw_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        busy;
    logic        cmd_valid;
    logic [0:0]  cmd_rank;
    logic [7:0]  cmd_mr_addr;
    logic [7:0]  cmd_mr_data;
    logic        cmd_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    mrw_engine dut_i (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_rank(cmd_rank), .cmd_mr_addr(cmd_mr_addr),
        .cmd_mr_data(cmd_mr_data), .cmd_ready(cmd_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
        csr_addr = a;
        #0.5;
        d = csr_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  ea, ed;
        bit          last;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", 32'(busy), 0);
        check("R1 cmd_valid", 32'(cmd_valid), 0);
        csr_read(2'd1, rd); check("R1 ctrl reset", rd, 0);
        csr_read(2'd2, rd); check("R1 data reset", rd, 0);
        csr_read(2'd0, rd); check("R1 status reset", rd, 0);

        for (int mask = 0; mask < 4; mask++) begin
            for (int stall = 0; stall < 3; stall++) begin
                ea = 8'(mask * 16 + stall + 1);
                ed = 8'hA5 ^ 8'(mask * 37 + stall);
                csr_write(2'd2, {16'hFFFF, ea, ed});
                csr_read(2'd2, rd);
                check("R2 data readback", rd, {16'h0, ea, ed});
                csr_write(2'd1, 32'h8000_0000 | 32'(mask << 4));
                csr_read(2'd1, rd);
                check("R3 ctrl readback without start bit", rd, 32'(mask << 4));
                if (mask == 0) begin
                    check("R9 no busy", 32'(busy), 0);
                    check("R9 no command", 32'(cmd_valid), 0);
                    continue;
                end
                csr_read(2'd0, rd);
                check("R4 status busy bit", rd, 1);
                for (int r = 0; r < 2; r++) begin
                    if (!mask[r]) continue;
                    last = (r == 1) || !mask[1];
                    check("R4 valid", 32'(cmd_valid), 1);
                    check("R5 rank order", 32'(cmd_rank), 32'(r));
                    check("R10 mr addr", 32'(cmd_mr_addr), 32'(ea));
                    check("R10 mr data", 32'(cmd_mr_data), 32'(ed));
                    for (int s = 0; s < stall; s++) begin
                        if (mask == 3 && r == 0 && s == 0) begin
                            csr_wr = 1'b1; csr_addr = 2'd1; csr_wdata = 32'h10;
                        end
                        @(negedge clk);
                        csr_wr = 1'b0;
                        check("R6 valid held", 32'(cmd_valid), 1);
                        check("R6 rank held", 32'(cmd_rank), 32'(r));
                        check("R6 data held", 32'(cmd_mr_data), 32'(ed));
                    end
                    cmd_ready = 1'b1;
                    if (last && stall == 1) begin
                        csr_wr = 1'b1; csr_addr = 2'd2; csr_wdata = 32'h0000_5A5A;
                    end
                    if (last && stall == 2) begin
                        csr_wr = 1'b1; csr_addr = 2'd1; csr_wdata = 32'h8000_0030;
                    end
                    @(negedge clk);
                    cmd_ready = 1'b0;
                    csr_wr = 1'b0;
                    if (!last) check("R5 busy between ranks", 32'(busy), 1);
                end
                check("R7 busy fell", 32'(busy), 0);
                check("R7 valid fell", 32'(cmd_valid), 0);
                csr_read(2'd2, rd);
                check("R8 data unchanged", rd, {16'h0, ea, ed});
                csr_read(2'd1, rd);
                check("R8 ctrl unchanged", rd, 32'(mask << 4));
                repeat (2) @(negedge clk);
                check("R8 no command from ignored start", 32'(cmd_valid), 0);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule